// File: doc/BRIEF.md
# Timer Compare Channel Pulse Output

This block sits next to a free-running time counter and watches its value on every clock. It holds four independent compare channels. Each channel has a control/status register and a compare register. When the counter equals a channel's armed compare value and the channel's mode is not zero, the channel raises its event flag. Depending on the mode, it also toggles its output pin or drives a one-clock pulse on it. A typical use is a once-per-second pulse output. Software keeps feeding the next compare value, and the event flag serves as the interrupt.

The compare register is double-buffered. A value written to an idle channel arms it at once. A value written while the channel is already armed waits in a holding slot and replaces the armed value at the next match. Software can therefore always stay one event ahead. A match that finds the holding slot empty disarms the channel. Writing a mode of zero disables the channel and empties both compare slots, so the next compare write arms the channel directly.

The flag of each channel is also gathered into a four-bit summary output. The counter and the reload arithmetic live outside this block.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, every control/status register reads zero, no compare value is armed, and all pins, flags, interrupt requests and DMA requests are low.
- R2: Control/status layout, as written and as read back: bit 0 is the DMA request enable, bits [5:2] are the mode, bit 6 is the interrupt enable, and bit 7 is the event flag. Bit 1 always reads zero.
- R3: When the counter input equals the armed compare value and the mode is nonzero, the flag reads 1 from the next clock onward. The flag also appears on `flag_sum[ch]`.
- R4: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves the flag unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R5: `irq[ch]` is high exactly when the flag and the interrupt enable are both set. `dma_req[ch]` is high exactly when the flag and the DMA enable are both set.
- R6: Mode 0x5 inverts the pin on every match and holds it between matches.
- R7: Mode 0xF drives the pin high for exactly the one clock that follows each match.
- R8: Any other nonzero mode sets the flag on a match but keeps the pin low.
- R9: A compare write to a channel that has no armed value arms it immediately. Reading the compare address returns the armed value.
- R10: A compare write to an armed channel is held back. The held value becomes the armed value after the current armed value matches, and it does not match before then.
- R11: A match with no held value disarms the channel. The counter passing the old value again sets no flag.
- R12: Writing a mode of 0, including writing the whole register as zero, disables matching, drives the pin low, and discards both the armed and the held compare value.
- R13: Register address = {channel, select}. Select 0 is control/status and select 1 is compare. A write or match on one channel leaves every other channel's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Current time counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+1 | Write address {channel, select} |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | CH_W+1 | Read address {channel, select} |
| rd_data | output | DATA_W | Combinational read data |
| evt_pin | output | NCH | Per-channel event output pin |
| irq | output | NCH | Per-channel interrupt request |
| dma_req | output | NCH | Per-channel DMA request |
| flag_sum | output | NCH | Summary of all channel event flags |

## Verification
A lost or swapped compare slot shows up at the first counter value the bench presents. Either the flag rises on the held value rather than the armed one, or the readback at the compare address returns the wrong value one clock after the write. A stale armed bit after a disable or a disarming match shows up as a spurious flag and interrupt on the very next pass of the counter over the old value. Pin state errors appear within one clock of a match, either as a pulse longer than one cycle or as a toggle that fails to invert or hold.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   localparam int unsigned MODE_W    = 4;
   localparam int unsigned CTRL_W    = 8;
   localparam int unsigned FLAG_BIT  = 7;

   localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
   localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
   localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

   // control/status register image, bit 7 down to bit 0
   typedef struct packed {
      logic              flag;
      logic              irq_en;
      logic [MODE_W-1:0] mode;
      logic              rsvd;
      logic              dma_en;
   } ctrl_t;
endpackage

// File: rtl/tcmp_cmp_buf.sv
module tcmp_cmp_buf #(
   parameter int unsigned CNT_W      = 32,
   parameter bit          DOUBLE_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_val_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] active_o
);
   logic [CNT_W-1:0] act_q;
   logic             act_vld_q;

   assign hit_o    = en_i && act_vld_q && (cnt_i == act_q);
   assign active_o = act_q;

   generate
      if (DOUBLE_BUF) begin : g_double
         logic [CNT_W-1:0] hold_q;
         logic             hold_vld_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_q      <= '0;
               act_vld_q  <= 1'b0;
               hold_q     <= '0;
               hold_vld_q <= 1'b0;
            end else if (clr_i) begin
               act_vld_q  <= 1'b0;
               hold_vld_q <= 1'b0;
            end else begin
               if (hit_o) begin
                  if (hold_vld_q) begin
                     act_q      <= hold_q;
                     hold_vld_q <= 1'b0;
                  end else begin
                     act_vld_q  <= 1'b0;
                  end
               end
               if (wr_i) begin
                  if (!act_vld_q || (hit_o && !hold_vld_q)) begin
                     act_q     <= wr_val_i;
                     act_vld_q <= 1'b1;
                  end else begin
                     hold_q     <= wr_val_i;
                     hold_vld_q <= 1'b1;
                  end
               end
            end
         end

         // R10: held value is promoted at a match
         p_promote_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o && hold_vld_q && !wr_i && !clr_i) |=> (act_vld_q && act_q == $past(hold_q) && !hold_vld_q));
         // R12: disable empties both slots
         p_clear_both_r12: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> (!act_vld_q && !hold_vld_q));
         // R11: a match with an empty holding slot disarms
         p_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_o && !hold_vld_q && !wr_i && !clr_i) |=> !act_vld_q);
      end else begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_q     <= '0;
               act_vld_q <= 1'b0;
            end else if (clr_i) begin
               act_vld_q <= 1'b0;
            end else if (wr_i) begin
               act_q     <= wr_val_i;
               act_vld_q <= 1'b1;
            end else if (hit_o) begin
               act_vld_q <= 1'b0;
            end
         end
      end
   endgenerate

   // R9: a write to an idle slot arms it at once
   p_first_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i && !act_vld_q) |=> (act_vld_q && act_q == $past(wr_val_i)));
endmodule

// File: rtl/tcmp_pin_gen.sv
module tcmp_pin_gen
   import tcmp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              hit_i,
   output logic              pin_o
);
   logic pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else begin
         unique case (mode_i)
            MODE_TOGGLE: pin_q <= hit_i ? ~pin_q : pin_q;
            MODE_PULSE:  pin_q <= hit_i;
            default:     pin_q <= 1'b0;
         endcase
      end
   end

   assign pin_o = pin_q;

   // R7: pulse mode pin mirrors exactly the previous cycle's match
   p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i) == MODE_PULSE) |-> (pin_q == $past(hit_i)));
   // R6: toggle mode holds without a match
   p_toggle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i) == MODE_TOGGLE && !$past(hit_i)) |-> (pin_q == $past(pin_q)));
   // R8 / R12: other modes keep the pin low
   p_other_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i) != MODE_TOGGLE && $past(mode_i) != MODE_PULSE) |-> !pin_q);
endmodule

// File: rtl/tcmp_chan.sv
module tcmp_chan
   import tcmp_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter bit          DOUBLE_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_ctrl_i,
   input  logic             wr_cmp_i,
   input  ctrl_t            ctrl_wr_i,
   input  logic [CNT_W-1:0] cmp_wr_i,
   output ctrl_t            ctrl_o,
   output logic [CNT_W-1:0] active_o,
   output logic             pin_o,
   output logic             irq_o,
   output logic             dma_o,
   output logic             flag_o
);
   logic              dma_en_q;
   logic              irq_en_q;
   logic [MODE_W-1:0] mode_q;
   logic              flag_q;
   logic              hit;
   logic              dis_req;
   logic              unused_rsvd;

   assign unused_rsvd = ctrl_wr_i.rsvd;
   assign dis_req     = wr_ctrl_i && (ctrl_wr_i.mode == MODE_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_en_q <= 1'b0;
         irq_en_q <= 1'b0;
         mode_q   <= MODE_OFF;
         flag_q   <= 1'b0;
      end else begin
         if (wr_ctrl_i) begin
            dma_en_q <= ctrl_wr_i.dma_en;
            irq_en_q <= ctrl_wr_i.irq_en;
            mode_q   <= ctrl_wr_i.mode;
         end
         if (hit)
            flag_q <= 1'b1;
         else if (wr_ctrl_i && ctrl_wr_i.flag)
            flag_q <= 1'b0;
      end
   end

   tcmp_cmp_buf #(.CNT_W(CNT_W), .DOUBLE_BUF(DOUBLE_BUF)) i_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_i),
      .en_i     (mode_q != MODE_OFF),
      .clr_i    (dis_req),
      .wr_i     (wr_cmp_i),
      .wr_val_i (cmp_wr_i),
      .hit_o    (hit),
      .active_o (active_o)
   );

   tcmp_pin_gen i_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_q),
      .hit_i  (hit),
      .pin_o  (pin_o)
   );

   always_comb begin
      ctrl_o        = '0;
      ctrl_o.flag   = flag_q;
      ctrl_o.irq_en = irq_en_q;
      ctrl_o.mode   = mode_q;
      ctrl_o.dma_en = dma_en_q;
   end

   assign irq_o  = flag_q & irq_en_q;
   assign dma_o  = flag_q & dma_en_q;
   assign flag_o = flag_q;

   // R3: the flag only rises after a match
   p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit));
   // R4: write-one clears when no match competes
   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_i && ctrl_wr_i.flag && !hit) |=> !flag_q);
   // R4: without a clearing write the flag stays set
   p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_ctrl_i && ctrl_wr_i.flag)) |=> flag_q);
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
   import tcmp_pkg::*;
#(
   parameter int unsigned NCH        = 4,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          DOUBLE_BUF = 1'b1,
   localparam int unsigned CH_W      = $clog2(NCH),
   localparam int unsigned ADDR_W    = CH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NCH-1:0]    evt_pin,
   output logic [NCH-1:0]    irq,
   output logic [NCH-1:0]    dma_req,
   output logic [NCH-1:0]    flag_sum
);
   generate
      if (NCH < 2) begin : g_bad_nch
         $error("tcmp_unit: NCH must be at least 2");
      end
      if (CNT_W > DATA_W || DATA_W < CTRL_W) begin : g_bad_width
         $error("tcmp_unit: CNT_W must fit in DATA_W and DATA_W must hold the control register");
      end
   endgenerate

   ctrl_t            ctrl_arr [NCH];
   logic [CNT_W-1:0] act_arr  [NCH];
   ctrl_t            ctrl_wr;

   assign ctrl_wr = ctrl_t'(wr_data[CTRL_W-1:0]);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = wr_en && (wr_addr[ADDR_W-1:1] == CH_W'(i));

      tcmp_chan #(.CNT_W(CNT_W), .DOUBLE_BUF(DOUBLE_BUF)) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_i     (cnt_i),
         .wr_ctrl_i (sel && !wr_addr[0]),
         .wr_cmp_i  (sel && wr_addr[0]),
         .ctrl_wr_i (ctrl_wr),
         .cmp_wr_i  (wr_data[CNT_W-1:0]),
         .ctrl_o    (ctrl_arr[i]),
         .active_o  (act_arr[i]),
         .pin_o     (evt_pin[i]),
         .irq_o     (irq[i]),
         .dma_o     (dma_req[i]),
         .flag_o    (flag_sum[i])
      );

      // R5: requests never appear without the flag
      p_req_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[i] || dma_req[i]) |-> flag_sum[i]);
      // R13: a channel not addressed keeps a clear flag clear unless it matched
      p_isolated_r13: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_sum[i] && !(ctrl_arr[i].mode != MODE_OFF && cnt_i == act_arr[i])) |=> !flag_sum[i]);
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr[ADDR_W-1:1] == CH_W'(i)) begin
            rd_data = rd_addr[0] ? DATA_W'(act_arr[i])
                                 : DATA_W'(ctrl_arr[i]);
         end
      end
   end
endmodule

// File: tb/test_tcmp_unit.sv
module test_tcmp_unit;
   localparam int unsigned NCH    = 4;
   localparam int unsigned CNT_W  = 32;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 3;
   localparam logic [31:0] IDLE   = 32'hFFFF_0000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [CNT_W-1:0]  cnt_i;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic [NCH-1:0]    evt_pin, irq, dma_req, flag_sum;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   tcmp_unit i_tcmp_unit (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .evt_pin(evt_pin),
      .irq(irq), .dma_req(dma_req), .flag_sum(flag_sum)
   );

   // {ch[1:0], ctrl[7:0], cmp[15:0], flag, irq, dma, pin}
   localparam logic [29:0] VEC [8] = '{
      {2'd0, 8'h54, 16'h0010, 4'b1101},
      {2'd1, 8'h3D, 16'h0020, 4'b1011},
      {2'd2, 8'h00, 16'h0030, 4'b0000},
      {2'd3, 8'h48, 16'h0040, 4'b1100},
      {2'd0, 8'h7D, 16'h0050, 4'b1111},
      {2'd1, 8'h41, 16'h0060, 4'b0000},
      {2'd2, 8'h14, 16'h0070, 4'b1001},
      {2'd3, 8'h3C, 16'h0080, 4'b1001}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int ch, input bit sel, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = {ch[1:0], sel};
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic hit_cnt(input logic [31:0] v);
      cnt_i = v;
      @(negedge clk);
      cnt_i = IDLE;
   endtask

   task automatic rd(input int ch, input bit sel, output logic [31:0] v);
      rd_addr = {ch[1:0], sel};
      #1 v = rd_data;
   endtask

   initial begin
      #2_000_000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; cnt_i = IDLE; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 flags", {28'd0, flag_sum}, 32'd0);
      chk("R1 pins/irq/dma", {20'd0, evt_pin, irq, dma_req}, 32'd0);
      for (int c = 0; c < NCH; c++) begin
         rd(c, 1'b0, v);
         chk("R1 ctrl readback", v, 32'd0);
      end
      hit_cnt(32'd0);
      chk("R1 unarmed no flag", {28'd0, flag_sum}, 32'd0);

      // table walk: R2 R3 R5 R6 R7 R8 R13
      for (int k = 0; k < 8; k++) begin
         int          ch;
         logic [7:0]  ct;
         logic [31:0] cm;
         ch = int'(VEC[k][29:28]);
         ct = VEC[k][27:20];
         cm = {16'd0, VEC[k][19:4]};
         wr(ch, 1'b0, 32'h80);
         wr(ch, 1'b0, {24'd0, ct});
         wr(ch, 1'b1, cm);
         rd(ch, 1'b0, v);
         chk("R2 ctrl readback", v, {24'd0, ct & 8'h7D});
         hit_cnt(cm);
         chk("R3 flag_sum", {31'd0, flag_sum[ch]}, {31'd0, VEC[k][3]});
         chk("R5 irq", {31'd0, irq[ch]}, {31'd0, VEC[k][2]});
         chk("R5 dma_req", {31'd0, dma_req[ch]}, {31'd0, VEC[k][1]});
         chk("R6/R7/R8 pin", {31'd0, evt_pin[ch]}, {31'd0, VEC[k][0]});
         rd(ch, 1'b0, v);
         chk("R2 flag bit 7", {31'd0, v[7]}, {31'd0, VEC[k][3]});
         chk("R13 single channel", {28'd0, flag_sum & ~(4'b1 << ch)}, 32'd0);
         wr(ch, 1'b0, 32'h80);
      end

      // R9 R10 R11 R7: double buffer on channel 1, pulse mode
      wr(1, 1'b0, 32'h3C);
      wr(1, 1'b1, 32'd100);
      wr(1, 1'b1, 32'd200);
      rd(1, 1'b1, v);
      chk("R9 first write active", v, 32'd100);
      hit_cnt(32'd200);
      chk("R10 held value not active", {31'd0, flag_sum[1]}, 32'd0);
      hit_cnt(32'd100);
      chk("R3 match on armed", {31'd0, flag_sum[1]}, 32'd1);
      chk("R7 pulse high", {31'd0, evt_pin[1]}, 32'd1);
      rd(1, 1'b1, v);
      chk("R10 promoted", v, 32'd200);
      @(negedge clk);
      chk("R7 pulse one cycle", {31'd0, evt_pin[1]}, 32'd0);
      wr(1, 1'b0, 32'hBC);
      chk("R4 w1c clears", {31'd0, flag_sum[1]}, 32'd0);
      hit_cnt(32'd200);
      chk("R10 second match", {31'd0, flag_sum[1]}, 32'd1);
      wr(1, 1'b0, 32'hBC);
      hit_cnt(32'd100);
      hit_cnt(32'd200);
      chk("R11 disarmed", {31'd0, flag_sum[1]}, 32'd0);

      // R4: write 0 to flag bit keeps it; set beats clear
      wr(2, 1'b0, 32'h08);
      wr(2, 1'b1, 32'd50);
      hit_cnt(32'd50);
      wr(2, 1'b0, 32'h08);
      chk("R4 zero write keeps flag", {31'd0, flag_sum[2]}, 32'd1);
      wr(2, 1'b0, 32'h88);
      chk("R4 w1c", {31'd0, flag_sum[2]}, 32'd0);
      wr(2, 1'b1, 32'd60);
      cnt_i = 32'd60;
      wr(2, 1'b0, 32'h88);
      cnt_i = IDLE;
      chk("R4 set beats clear", {31'd0, flag_sum[2]}, 32'd1);
      wr(2, 1'b0, 32'h80);

      // R6: toggle across two matches with buffered value
      wr(0, 1'b0, 32'h14);
      wr(0, 1'b1, 32'd10);
      wr(0, 1'b1, 32'd30);
      hit_cnt(32'd10);
      chk("R6 toggle up", {31'd0, evt_pin[0]}, 32'd1);
      repeat (2) @(negedge clk);
      chk("R6 hold", {31'd0, evt_pin[0]}, 32'd1);
      hit_cnt(32'd30);
      chk("R6 toggle down", {31'd0, evt_pin[0]}, 32'd0);
      wr(0, 1'b0, 32'h80);

      // R12: writing zero disables and discards compare
      wr(3, 1'b0, 32'h14);
      wr(3, 1'b1, 32'd70);
      wr(3, 1'b1, 32'd90);
      hit_cnt(32'd70);
      chk("R12 pin set before disable", {31'd0, evt_pin[3]}, 32'd1);
      wr(3, 1'b0, 32'h80);
      wr(3, 1'b0, 32'h00);
      @(negedge clk);
      chk("R12 pin low", {31'd0, evt_pin[3]}, 32'd0);
      hit_cnt(32'd90);
      chk("R12 disabled no flag", {31'd0, flag_sum[3]}, 32'd0);
      wr(3, 1'b0, 32'h3C);
      hit_cnt(32'd90);
      chk("R12 held value discarded", {31'd0, flag_sum[3]}, 32'd0);
      wr(3, 1'b1, 32'd95);
      rd(3, 1'b1, v);
      chk("R12 next write arms", v, 32'd95);
      chk("R13 others clear", {28'd0, flag_sum}, 32'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule